// File: doc/BRIEF.md
# Processor Counter with User-Timer Mode

This block is the timer that belongs to one processor. A mode input chooses between two personalities. In counter mode it is a limit timer. A count advances on every tick enable pulse. When the count meets a programmed limit, it returns to zero, sets a reached flag and raises an interrupt. Software clears the flag and the interrupt by reading the limit back.

In user-timer mode the same storage becomes a wide count. Software reads and preloads it as an upper and a lower 32-bit word, and starts and stops it through a control word. This mode never interrupts.

Every count value is kept in units of 0x200, one unit for each tick, so bits 8..0 of any count word read as zero. Registers are addressed by word: addr 0 is byte offset 0x0, addr 1 is 0x4, addr 2 is 0x8 and addr 3 is 0xC. The mode bit itself lives outside this block and arrives as a level on `user_mode`.

Top module: `pcpu_timer`

## Requirements
- R1: After reset the block is in counter mode, with limit, count and reached flag at zero, `irq` low and the running flag (read at addr 3, bit 0) equal to 1.
- R2: In counter mode a tick advances the count read at addr 1 by 0x200. A write to addr 0 sets the limit to wdata & 0x7FFFFE00, clears the count and lowers `irq`. A write to addr 2 sets the limit the same way but keeps the count. A write to addr 1 is ignored.
- R3: In counter mode with a nonzero limit, a tick that would bring the count to the limit returns it to zero instead. That tick also sets the reached flag (bit 31 of the addr 1 word) and raises `irq` on the following clock edge. With a limit of zero the count runs free, and it never sets the reached flag or raises `irq`.
- R4: In counter mode a read strobe at addr 0 returns the limit and clears both the reached flag and `irq`.
- R5: In counter mode the count always runs and addr 3 reads 1. A write to addr 3 has no effect.
- R6: When `user_mode` goes from 0 to 1, the block lowers `irq`, clears the running flag, and clears the count and the reached flag.
- R7: In user-timer mode addr 0 reads {reached, count bits 62..32} and addr 1 reads count bits 31..0 with bits 8..0 zero. Addr 2 reads zero, and reads have no side effects.
- R8: In user-timer mode a write to addr 0 loads count bits 62..32 from wdata[30:0], and a write to addr 1 loads count bits 31..9 from wdata[31:9]. Either write clears the reached flag, and counting carries on from the combined value.
- R9: In user-timer mode, writing 1 to bit 0 of addr 3 starts the count and writing 0 stops it. The count advances on ticks only while it is running, and a repeated start or stop changes nothing.
- R10: In user-timer mode, a tick that brings the count to 0x7FFFFFFFFFFFFE00 returns it to zero and sets the reached flag, and `irq` stays low.
- R11: When `user_mode` goes from 1 to 0, the block sets the running flag and clears the limit, the count, the reached flag and `irq`, so counting resumes free-running from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one pulse per count unit |
| user_mode | input | 1 | 1 selects user-timer mode, 0 counter mode |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt, counter mode only |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high together. They also assume that no register access falls in the cycle where `user_mode` differs from the mode the block last took up, since that cycle is spent on the switch and drops the access. A read that clears the flag is assumed not to meet a limit-matching tick on the same edge. The stimulus keeps within these limits: it changes `user_mode` only in an idle cycle, issues one strobe at a time, and pulses `tick` only in cycles with no register access.

// File: rtl/pcpu_timer.sv
module pcpu_timer #(
  parameter int DW        = 32,
  parameter int FRAC_BITS = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          user_mode,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int CP = DW - 1 - FRAC_BITS;
  localparam int UP = 2 * DW - 1 - FRAC_BITS;
  localparam int HI = DW - FRAC_BITS;
  localparam logic [UP-1:0] ONE = {{(UP-1){1'b0}}, 1'b1};

  logic          mode_q, run_q, reached_q, irq_q;
  logic [CP-1:0] lim_q;
  logic [UP-1:0] cnt_q;

  wire           mode_chg = user_mode != mode_q;
  wire           wr       = wr_en && !mode_chg;
  wire           rd       = rd_en && !mode_chg;
  wire [UP-1:0]  cnt_inc  = cnt_q + ONE;
  wire [CP-1:0]  lim_end  = (lim_q == '0) ? {CP{1'b1}} : lim_q;
  wire           ctr_hit  = cnt_inc[CP-1:0] >= lim_end;
  wire           usr_hit  = &cnt_inc;
  wire           lim_set  = lim_q != '0;
  wire           unused_wbits = ^wdata[FRAC_BITS-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      run_q     <= 1'b1;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
      lim_q     <= '0;
      cnt_q     <= '0;
    end else if (mode_chg) begin
      mode_q    <= user_mode;
      run_q     <= !user_mode;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
      lim_q     <= '0;
      cnt_q     <= '0;
    end else if (mode_q) begin
      if (wr && addr == 2'd0) begin
        cnt_q[UP-1:HI] <= wdata[DW-2:0];
        reached_q      <= 1'b0;
      end else if (wr && addr == 2'd1) begin
        cnt_q[HI-1:0]  <= wdata[DW-1:FRAC_BITS];
        reached_q      <= 1'b0;
      end else if (tick && run_q) begin
        if (usr_hit) begin
          cnt_q     <= '0;
          reached_q <= 1'b1;
        end else begin
          cnt_q     <= cnt_inc;
        end
      end
      if (wr && addr == 2'd3)
        run_q <= wdata[0];
    end else begin
      if (wr && addr == 2'd0) begin
        lim_q <= wdata[DW-2:FRAC_BITS];
        cnt_q <= '0;
        irq_q <= 1'b0;
      end else begin
        if (rd && addr == 2'd0) begin
          reached_q <= 1'b0;
          irq_q     <= 1'b0;
        end
        if (wr && addr == 2'd2)
          lim_q <= wdata[DW-2:FRAC_BITS];
        if (tick) begin
          if (ctr_hit) begin
            cnt_q <= '0;
            if (lim_set) begin
              reached_q <= 1'b1;
              irq_q     <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_inc;
          end
        end
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0: rdata = mode_q ? {reached_q, cnt_q[UP-1:HI]}
                           : {1'b0, lim_q, {FRAC_BITS{1'b0}}};
      2'd1: rdata = mode_q ? {cnt_q[HI-1:0], {FRAC_BITS{1'b0}}}
                           : {reached_q, cnt_q[CP-1:0], {FRAC_BITS{1'b0}}};
      2'd3: rdata = {{(DW-1){1'b0}}, run_q};
      default: rdata = '0;
    endcase
  end

  assign irq = irq_q;
endmodule

// File: rtl/pcpu_timer_chk.sv
module pcpu_timer_chk #(
  parameter int UP = 54
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          user_mode,
  input logic          wr_en,
  input logic          rd_en,
  input logic [1:0]    addr,
  input logic          irq,
  input logic          mode_q,
  input logic          run_q,
  input logic [UP-1:0] cnt_q
);
  localparam logic [UP-1:0] ONE = {{(UP-1){1'b0}}, 1'b1};

  a_r10_user_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $past(user_mode) |-> !irq);

  a_r9_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && user_mode && !run_q && !wr_en) |=> $stable(cnt_q));

  a_r9_running_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && user_mode && run_q && tick && !wr_en)
      |=> (cnt_q == $past(cnt_q) + ONE || cnt_q == '0));

  a_r5_counter_runs: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> run_q);

  a_r3_irq_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && !mode_q && !user_mode && !tick) |=> !irq);
endmodule

bind pcpu_timer pcpu_timer_chk #(.UP(UP)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .irq(irq),
  .mode_q(mode_q), .run_q(run_q), .cnt_q(cnt_q)
);

// File: tb/pcpu_timer_tb.sv
module pcpu_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        user_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcpu_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  // op: 0 write, 1 read strobe+check, 2 ticks, 3 mode, 4 peek, 5 irq check
  // fields {op[3:0], req[3:0], addr[1:0], data[31:0], exp[31:0]}
  localparam int NA = 33;
  localparam int NB = 49;
  localparam logic [73:0] TA [NA] = '{
    {4'd4, 4'd1,  2'd1, 32'h0,        32'h0},        // R1 count
    {4'd4, 4'd1,  2'd3, 32'h0,        32'h1},        // R1 running
    {4'd4, 4'd1,  2'd0, 32'h0,        32'h0},        // R1 limit
    {4'd5, 4'd1,  2'd0, 32'h0,        32'h0},        // R1 irq
    {4'd0, 4'd2,  2'd0, 32'h00000A00, 32'h0},
    {4'd2, 4'd2,  2'd0, 32'd3,        32'h0},
    {4'd4, 4'd2,  2'd1, 32'h0,        32'h00000600}, // R2 advance
    {4'd5, 4'd3,  2'd0, 32'h0,        32'h0},        // R3 no early irq
    {4'd2, 4'd3,  2'd0, 32'd2,        32'h0},
    {4'd4, 4'd3,  2'd1, 32'h0,        32'h80000000}, // R3 wrap+reached
    {4'd5, 4'd3,  2'd0, 32'h0,        32'h1},        // R3 irq
    {4'd1, 4'd4,  2'd0, 32'h0,        32'h00000A00}, // R4 read limit
    {4'd5, 4'd4,  2'd0, 32'h0,        32'h0},        // R4 irq cleared
    {4'd4, 4'd4,  2'd1, 32'h0,        32'h0},        // R4 reached cleared
    {4'd0, 4'd2,  2'd1, 32'h12345600, 32'h0},
    {4'd4, 4'd2,  2'd1, 32'h0,        32'h0},        // R2 addr1 write ignored
    {4'd0, 4'd5,  2'd3, 32'h0,        32'h0},
    {4'd2, 4'd5,  2'd0, 32'd2,        32'h0},
    {4'd4, 4'd5,  2'd1, 32'h0,        32'h00000400}, // R5 stop ignored
    {4'd4, 4'd5,  2'd3, 32'h0,        32'h1},        // R5 running
    {4'd0, 4'd2,  2'd2, 32'h00000600, 32'h0},
    {4'd4, 4'd2,  2'd1, 32'h0,        32'h00000400}, // R2 count kept
    {4'd2, 4'd3,  2'd0, 32'd1,        32'h0},
    {4'd4, 4'd3,  2'd1, 32'h0,        32'h80000000}, // R3 new limit hit
    {4'd0, 4'd2,  2'd0, 32'h000001FF, 32'h0},
    {4'd5, 4'd2,  2'd0, 32'h0,        32'h0},        // R2 write lowers irq
    {4'd1, 4'd4,  2'd0, 32'h0,        32'h0},        // R4 masked limit zero
    {4'd2, 4'd3,  2'd0, 32'd4,        32'h0},
    {4'd4, 4'd3,  2'd1, 32'h0,        32'h00000800}, // R3 free-run
    {4'd5, 4'd3,  2'd0, 32'h0,        32'h0},        // R3 free-run no irq
    {4'd0, 4'd2,  2'd0, 32'h00000400, 32'h0},
    {4'd2, 4'd3,  2'd0, 32'd2,        32'h0},
    {4'd5, 4'd3,  2'd0, 32'h0,        32'h1}         // R3 irq before switch
  };
  localparam logic [73:0] TB [NB] = '{
    {4'd3, 4'd6,  2'd0, 32'h1,        32'h0},
    {4'd5, 4'd6,  2'd0, 32'h0,        32'h0},        // R6 irq lowered
    {4'd4, 4'd6,  2'd3, 32'h0,        32'h0},        // R6 stopped
    {4'd4, 4'd6,  2'd0, 32'h0,        32'h0},        // R6 upper/reached
    {4'd4, 4'd6,  2'd1, 32'h0,        32'h0},        // R6 lower
    {4'd2, 4'd9,  2'd0, 32'd3,        32'h0},
    {4'd4, 4'd9,  2'd1, 32'h0,        32'h0},        // R9 no count stopped
    {4'd0, 4'd9,  2'd3, 32'h1,        32'h0},
    {4'd2, 4'd9,  2'd0, 32'd3,        32'h0},
    {4'd4, 4'd9,  2'd1, 32'h0,        32'h00000600}, // R9 started
    {4'd0, 4'd9,  2'd3, 32'h1,        32'h0},
    {4'd4, 4'd9,  2'd3, 32'h0,        32'h1},        // R9 repeat start
    {4'd2, 4'd9,  2'd0, 32'd1,        32'h0},
    {4'd4, 4'd9,  2'd1, 32'h0,        32'h00000800}, // R9 still counting
    {4'd0, 4'd9,  2'd3, 32'h0,        32'h0},
    {4'd2, 4'd9,  2'd0, 32'd2,        32'h0},
    {4'd4, 4'd9,  2'd1, 32'h0,        32'h00000800}, // R9 stop holds
    {4'd0, 4'd9,  2'd3, 32'h0,        32'h0},
    {4'd4, 4'd9,  2'd3, 32'h0,        32'h0},        // R9 repeat stop
    {4'd0, 4'd8,  2'd0, 32'h00000001, 32'h0},
    {4'd4, 4'd8,  2'd0, 32'h0,        32'h00000001}, // R8 upper load
    {4'd4, 4'd8,  2'd1, 32'h0,        32'h00000800}, // R8 lower kept
    {4'd0, 4'd8,  2'd1, 32'hFFFFFFFF, 32'h0},
    {4'd4, 4'd8,  2'd1, 32'h0,        32'hFFFFFE00}, // R8 lower masked
    {4'd0, 4'd9,  2'd3, 32'h1,        32'h0},
    {4'd2, 4'd8,  2'd0, 32'd1,        32'h0},
    {4'd4, 4'd8,  2'd0, 32'h0,        32'h00000002}, // R8 carry to upper
    {4'd4, 4'd8,  2'd1, 32'h0,        32'h0},        // R8 lower wrapped
    {4'd0, 4'd8,  2'd0, 32'hFFFFFFFF, 32'h0},
    {4'd0, 4'd8,  2'd1, 32'hFFFFFC00, 32'h0},
    {4'd4, 4'd8,  2'd0, 32'h0,        32'h7FFFFFFF}, // R8 upper masked
    {4'd4, 4'd8,  2'd1, 32'h0,        32'hFFFFFC00}, // R8 lower preload
    {4'd2, 4'd10, 2'd0, 32'd1,        32'h0},
    {4'd4, 4'd10, 2'd0, 32'h0,        32'h80000000}, // R10 max wraps
    {4'd4, 4'd10, 2'd1, 32'h0,        32'h0},        // R10 lower zero
    {4'd5, 4'd10, 2'd0, 32'h0,        32'h0},        // R10 no irq
    {4'd1, 4'd7,  2'd0, 32'h0,        32'h80000000}, // R7 read upper
    {4'd4, 4'd7,  2'd0, 32'h0,        32'h80000000}, // R7 no side effect
    {4'd4, 4'd7,  2'd2, 32'h0,        32'h0},        // R7 addr2 zero
    {4'd0, 4'd8,  2'd1, 32'h00000400, 32'h0},
    {4'd4, 4'd8,  2'd0, 32'h0,        32'h0},        // R8 reached cleared
    {4'd4, 4'd8,  2'd1, 32'h0,        32'h00000400}, // R8 lower load
    {4'd3, 4'd11, 2'd0, 32'h0,        32'h0},
    {4'd4, 4'd11, 2'd3, 32'h0,        32'h1},        // R11 running
    {4'd4, 4'd11, 2'd0, 32'h0,        32'h0},        // R11 limit zero
    {4'd4, 4'd11, 2'd1, 32'h0,        32'h0},        // R11 count zero
    {4'd2, 4'd11, 2'd0, 32'd2,        32'h0},
    {4'd4, 4'd11, 2'd1, 32'h0,        32'h00000400}, // R11 counts again
    {4'd5, 4'd11, 2'd0, 32'h0,        32'h0}         // R11 irq low
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input int req, input logic [1:0] a, input logic [31:0] exp);
    rd_en = 1'b1; addr = a;
    #1 check(req, rdata, exp);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_tick(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic peek(input int req, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #1 check(req, rdata, exp);
  endtask

  task automatic apply(input logic [73:0] v);
    logic [3:0]  op;
    logic [3:0]  req;
    logic [1:0]  a;
    logic [31:0] d, e;
    {op, req, a, d, e} = v;
    case (op)
      4'd0: do_wr(a, d);
      4'd1: do_rd(int'(req), a, e);
      4'd2: do_tick(int'(d));
      4'd3: begin
        user_mode = d[0];
        @(posedge clk); @(negedge clk);
      end
      4'd4: peek(int'(req), a, e);
      default: begin
        #1 check(int'(req), {31'b0, irq}, e);
      end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NA + NB; i++)
      apply(i < NA ? TA[i] : TB[i - NA]);

    // R3 corner: single-unit limit matches on the first tick
    do_wr(2'd0, 32'h00000200);
    do_tick(1);
    peek(3, 2'd1, 32'h80000000);
    #1 check(3, {31'b0, irq}, 32'h1);

    // R1: reset from an active state
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1 check(1, {31'b0, irq}, 32'h0);
    peek(1, 2'd1, 32'h0);
    peek(1, 2'd0, 32'h0);
    peek(1, 2'd3, 32'h1);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule